// File: doc/BRIEF.md
# Five-Digit Code Lock Controller

This block is a clocked code lock. On every clock cycle it samples one code digit together with a start marker that flags the opening digit of an attempt. Digits are grouped into back-to-back windows of fixed length, and the window grid starts at reset. At the end of each window the block gives one verdict. `unlock` pulses for one cycle when all digits matched the stored code and the start marker was used correctly. `warning` pulses for one cycle when anything in the window was wrong.

The verdict always comes out on the window grid. An early mismatch is remembered, and its result is only reported at the window's end. Failed attempts are counted, and a correct attempt clears the count. When the failure limit is reached, the block enters lockout. In lockout `warning` stays high, `unlock` stays low, and the code inputs are ignored until reset.

Top module: `code_lock_ctrl`

## Requirements
- R1: Windows are SEQ_LEN cycles long and follow one another without gaps. The first window begins with the first rising edge at which `rst_n` is sampled high. Outside lockout, `unlock` and `warning` are both 0 except in the single cycle after the last digit of a window has been sampled.
- R2: A window is a pass when its digits equal the stored code in order, and the default code is 36, 19, 56, 101, 73. A pass also needs `start_mark` to be 1 on the first digit and 0 on every other digit. A pass gives `unlock`=1 and `warning`=0 for one cycle.
- R3: A digit that differs from the stored code at its position makes the window a fail, giving `warning`=1 and `unlock`=0. Correct digits later in the same window do not undo the fail.
- R4: A window fails if `start_mark` is 0 on its first digit, or if `start_mark` is 1 on any later digit.
- R5: `unlock` and `warning` are never 1 in the same cycle.
- R6: Each fail adds one to a failure count, and each pass clears the count to zero.
- R7: The MAX_FAILS-th fail since the last pass or reset (default 3) enters lockout in the same cycle as its `warning` verdict. In lockout, `warning` is held at 1 and `unlock` at 0 on every cycle.
- R8: In lockout, `code_digit` and `start_mark` have no effect, and even a correct window leaves the outputs at `unlock`=0, `warning`=1.
- R9: Reset is synchronous and active-low. A rising edge that samples `rst_n` low leaves lockout, clears both outputs and the failure count, and restarts the window grid, including when it happens partway through a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_digit | input | DIGIT_W | Code digit sampled this cycle |
| start_mark | input | 1 | 1 on the opening digit of an attempt |
| unlock | output | 1 | One-cycle pass verdict |
| warning | output | 1 | One-cycle fail verdict; held high in lockout |

## Verification
The bench builds the block with its default parameters: 8-bit digits, five-digit windows, the default code, and lockout on the third fail. With these values, one table walk reaches several things: the pass, a late-digit mismatch, a missing start marker, an extra start marker, a sticky early mismatch, and a pass that clears the count. It then reaches lockout from exactly three fails in a row. Directed tests follow. They feed a correct code during lockout, apply reset from lockout and partway through a window, and confirm that the count restarts from zero after reset.

// File: rtl/code_lock_pkg.sv
// Shared types for the code lock controller.
package code_lock_pkg;
    // Top-level controller state: normal checking or latched lockout.
    typedef enum logic {
        ST_CHECK = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;
endpackage

// File: rtl/lock_window_ctr.sv
// Window position counter.
// Steps through positions 0..SEQ_LEN-1 once per cycle and wraps, so windows
// follow one another with no gaps. Assumes SEQ_LEN >= 2. Reset puts the
// counter back at position 0.
module lock_window_ctr #(
    parameter int SEQ_LEN = 5,
    localparam int POS_W = $clog2(SEQ_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos,
    output logic             is_first,
    output logic             is_last
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(SEQ_LEN - 1);

    logic [POS_W-1:0] pos_q;

    // Advance the position every cycle and wrap after the last digit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (pos_q == LAST_POS) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + POS_W'(1);
        end
    end

    assign pos      = pos_q;
    assign is_first = (pos_q == '0);
    assign is_last  = (pos_q == LAST_POS);

    assert_pos_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST_POS);
    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == LAST_POS) |=> (pos_q == '0));
endmodule

// File: rtl/lock_match_tracker.sv
// Per-window match tracker.
// Compares each digit with the stored code at the current position and checks
// that the start marker appears only on the first digit. Any miss sets a
// sticky flag that lasts until the end of the window. On the last position it
// raises a pass or fail strobe. When en is low the strobes stay quiet.
// CODE holds digit 0 in its most significant DIGIT_W bits.
module lock_match_tracker #(
    parameter int DIGIT_W = 8,
    parameter int SEQ_LEN = 5,
    parameter logic [SEQ_LEN*DIGIT_W-1:0] CODE = '0,
    localparam int POS_W = $clog2(SEQ_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [DIGIT_W-1:0] digit,
    input  logic               mark,
    input  logic [POS_W-1:0]   pos,
    input  logic               is_first,
    input  logic               is_last,
    output logic               pass_stb,
    output logic               fail_stb
);
    logic [DIGIT_W-1:0] code_a [SEQ_LEN];
    logic               miss_q;
    logic               digit_ok;
    logic               mark_ok;
    logic               step_ok;

    // Unpack the flat code parameter into one entry per position.
    for (genvar g = 0; g < SEQ_LEN; g++) begin : g_code
        assign code_a[g] = CODE[(SEQ_LEN-1-g)*DIGIT_W +: DIGIT_W];
    end

    assign digit_ok = (digit == code_a[pos]);
    assign mark_ok  = (mark == is_first);
    assign step_ok  = digit_ok && mark_ok;

    // Sticky miss flag: set by any bad step, cleared when the window ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q <= 1'b0;
        end else if (is_last) begin
            miss_q <= 1'b0;
        end else if (!step_ok) begin
            miss_q <= 1'b1;
        end
    end

    assign pass_stb = en && is_last && !miss_q && step_ok;
    assign fail_stb = en && is_last && (miss_q || !step_ok);

    assert_sticky_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_q && !is_last) |=> miss_q);
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_stb && fail_stb));
endmodule

// File: rtl/lock_fail_ctr.sv
// Failure counter.
// Counts fail strobes and clears on a pass strobe. limit_hit flags the fail
// that brings the count to MAX_FAILS. The count saturates at MAX_FAILS.
// Assumes MAX_FAILS >= 1.
module lock_fail_ctr #(
    parameter int MAX_FAILS = 3,
    localparam int CNT_W = $clog2(MAX_FAILS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pass_stb,
    input  logic fail_stb,
    output logic limit_hit
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_FAILS);

    logic [CNT_W-1:0] cnt_q;

    // Track consecutive fails; a pass clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pass_stb) begin
            cnt_q <= '0;
        end else if (fail_stb && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign limit_hit = fail_stb && (cnt_q == LIMIT - CNT_W'(1));

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
    assert_pass_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_stb |=> (cnt_q == '0));
endmodule

// File: rtl/code_lock_ctrl.sv
// Code lock controller top.
// Puts together the window counter, the match tracker and the failure
// counter, and holds the check/lockout state and the registered verdict
// outputs. Verdicts last one cycle. Lockout holds warning high until a
// synchronous active-low reset. Inputs are sampled on every rising edge.
module code_lock_ctrl
    import code_lock_pkg::*;
#(
    parameter int DIGIT_W   = 8,
    parameter int SEQ_LEN   = 5,
    parameter int MAX_FAILS = 3,
    parameter logic [SEQ_LEN*DIGIT_W-1:0] CODE =
        {8'd36, 8'd19, 8'd56, 8'd101, 8'd73},
    localparam int POS_W = $clog2(SEQ_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] code_digit,
    input  logic               start_mark,
    output logic               unlock,
    output logic               warning
);
    lock_state_e      state_q;
    logic [POS_W-1:0] pos;
    logic             is_first;
    logic             is_last;
    logic             pass_stb;
    logic             fail_stb;
    logic             limit_hit;
    logic             unlock_q;
    logic             warning_q;

    lock_window_ctr #(.SEQ_LEN(SEQ_LEN)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos      (pos),
        .is_first (is_first),
        .is_last  (is_last)
    );

    lock_match_tracker #(
        .DIGIT_W (DIGIT_W),
        .SEQ_LEN (SEQ_LEN),
        .CODE    (CODE)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state_q == ST_CHECK),
        .digit    (code_digit),
        .mark     (start_mark),
        .pos      (pos),
        .is_first (is_first),
        .is_last  (is_last),
        .pass_stb (pass_stb),
        .fail_stb (fail_stb)
    );

    lock_fail_ctr #(.MAX_FAILS(MAX_FAILS)) u_fails (
        .clk       (clk),
        .rst_n     (rst_n),
        .pass_stb  (pass_stb),
        .fail_stb  (fail_stb),
        .limit_hit (limit_hit)
    );

    // State and verdict registers: pulse verdicts while checking, hold in lockout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_CHECK;
            unlock_q  <= 1'b0;
            warning_q <= 1'b0;
        end else begin
            case (state_q)
                ST_CHECK: begin
                    unlock_q  <= pass_stb;
                    warning_q <= fail_stb;
                    if (limit_hit) begin
                        state_q <= ST_LOCKED;
                    end
                end
                default: begin
                    unlock_q  <= 1'b0;
                    warning_q <= 1'b1;
                end
            endcase
        end
    end

    assign unlock  = unlock_q;
    assign warning = warning_q;

    assert_out_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlock_q && warning_q));
    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |=> (state_q == ST_LOCKED));
    assert_lock_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |-> (warning_q && !unlock_q));
    assert_lock_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_hit && state_q == ST_CHECK) |=> (state_q == ST_LOCKED && warning_q));
endmodule

// File: tb/tb_code_lock_ctrl.sv
module tb_code_lock_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] code_digit = '0;
    logic       start_mark = 1'b0;
    logic       unlock;
    logic       warning;
    int         n_checks = 0;
    int         n_errors = 0;

    always #4 clk = ~clk;

    code_lock_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_digit (code_digit),
        .start_mark (start_mark),
        .unlock     (unlock),
        .warning    (warning)
    );

    localparam logic [39:0] GOOD = {8'd36, 8'd19, 8'd56, 8'd101, 8'd73};
    localparam int NV = 7;
    // Window digits (first digit in the top byte), start marks (bit 4 = first), expected {unlock,warning}.
    localparam logic [39:0] V_DIG [NV] = '{
        GOOD,                                     // R2 pass
        {8'd36, 8'd19, 8'd56, 8'd100, 8'd73},     // R3 wrong fourth digit
        GOOD,                                     // R4 missing start mark
        GOOD,                                     // R6 pass clears count
        {8'd36, 8'd20, 8'd56, 8'd101, 8'd73},     // R3 early miss is sticky
        GOOD,                                     // R4 extra start mark
        40'd0                                     // R7 third fail -> lockout
    };
    localparam logic [4:0] V_MARK [NV] = '{
        5'b10000, 5'b10000, 5'b00000, 5'b10000, 5'b10000, 5'b10010, 5'b00000
    };
    localparam logic [1:0] V_EXP [NV] = '{
        2'b10, 2'b01, 2'b01, 2'b10, 2'b01, 2'b01, 2'b01
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: {unlock,warning} got %b expected %b", req, act, exp);
        end
    endtask

    // Called at a negedge; runs one window and checks every cycle.
    task automatic run_window(input logic [39:0] digs, input logic [4:0] marks,
                              input logic [1:0] mid_exp, input logic [1:0] end_exp,
                              input string req);
        for (int k = 0; k < 5; k++) begin
            code_digit = digs[(4-k)*8 +: 8];
            start_mark = marks[4-k];
            @(posedge clk);
            @(negedge clk);
            if (k < 4) check({req, " R1 mid-window"}, {unlock, warning}, mid_exp);
            else       check(req, {unlock, warning}, end_exp);
        end
    endtask

    task automatic apply_reset(input int cycles);
        rst_n = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            @(negedge clk);
            check("R9 reset", {unlock, warning}, 2'b00);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        apply_reset(2);
        // Table walk over back-to-back windows.
        for (int i = 0; i < NV; i++) begin
            run_window(V_DIG[i], V_MARK[i], 2'b00, V_EXP[i], $sformatf("R2/R3/R4/R6/R7 vec%0d", i));
        end
        // R8: in lockout a correct window changes nothing.
        run_window(GOOD, 5'b10000, 2'b01, 2'b01, "R8 lockout ignores code");
        run_window(40'd0, 5'b11111, 2'b01, 2'b01, "R8 lockout ignores marks");
        // R9: reset leaves lockout.
        apply_reset(1);
        run_window(GOOD, 5'b10000, 2'b00, 2'b10, "R9 pass after lockout reset");
        // R9: count cleared by reset: two fails then reset must not lock on the next fail.
        run_window(40'd0, 5'b10000, 2'b00, 2'b01, "R6 fail one");
        run_window(40'd0, 5'b10000, 2'b00, 2'b01, "R6 fail two");
        apply_reset(1);
        run_window(40'd0, 5'b10000, 2'b00, 2'b01, "R9 fail after reset");
        run_window(GOOD, 5'b10000, 2'b00, 2'b10, "R9 count cleared, no lockout");
        // R9: reset partway through a window realigns the grid.
        code_digit = 8'd36; start_mark = 1'b1;
        @(posedge clk); @(negedge clk);
        code_digit = 8'd19; start_mark = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 partial window quiet", {unlock, warning}, 2'b00);
        apply_reset(1);
        run_window(GOOD, 5'b10000, 2'b00, 2'b10, "R9 pass after mid-window reset");
        // R5 and R3: late correct digits after an early miss still fail.
        run_window({8'd0, 8'd19, 8'd56, 8'd101, 8'd73}, 5'b10000, 2'b00, 2'b01, "R3 first digit wrong");
        run_window(GOOD, 5'b11000, 2'b00, 2'b01, "R4 mark on second digit");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule